// File: doc/BRIEF.md
# SPI Byte-Pattern Trigger

This block watches an SPI bus without driving it. It brings SCLK, chip select, MOSI and MISO into the system clock domain and rebuilds bytes from both data lines at once. The bytes are counted from the start of each chip-select frame. The first N bytes of a frame are compared against a configured pattern. When every compared byte matches, the block raises a trigger for a single clock cycle. A logic-analyser capture engine can use that pulse to place a transaction of interest in its acquisition window.

Each pattern position has a byte value and a care flag. A cleared care flag makes that position a wildcard. A separate value and care table is kept for each data line. The line selector picks the MOSI table alone, the MISO table alone, or both tables, in which case both must hit at every position. The pattern length, the chip-select polarity and the line selector are static configuration inputs. The bus is sampled in one fixed mode: data is taken on the rising SCLK edge, MSB first.

Top module: `spi_pattern_trigger`

## Requirements
- R1: After reset, trig_o is low, and it stays low until a pattern match completes.
- R2: With cfg_line_i = 0, only MOSI bytes are compared, against cfg_mosi_val_i and cfg_mosi_care_i. Frame byte k uses bits [8k+7:8k] of the value and bit k of the care mask.
- R3: With cfg_line_i = 1, only MISO bytes are compared, against cfg_miso_val_i and cfg_miso_care_i, using the same field positions as R2.
- R4: With cfg_line_i = 2 or 3, each position must match both the MOSI table and the MISO table for the trigger to fire.
- R5: A byte position whose care bit is 0 matches any received byte on that line.
- R6: cfg_len_i holds N-1 for a pattern of N bytes (1 to 4). Bytes after position N-1 have no effect. The trigger follows the last bit of byte N-1.
- R7: Byte positions are counted from chip-select assertion. Pattern bytes that appear at a later offset do not trigger.
- R8: cfg_cs_pol_i = 0 makes chip select active low, and 1 makes it active high.
- R9: If chip select deasserts before byte N-1 is complete, the partial match and any partial byte are discarded. No trigger fires, and the next frame starts from position 0.
- R10: trig_o is high for exactly one clock cycle, and it fires at most once per chip-select frame.
- R11: Bits are taken on the rising SCLK edge, MSB first. trig_o rises 4 system clocks after the rising SCLK edge that completes the pattern reaches the input pins.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock (asynchronous) |
| cs_i | input | 1 | SPI chip select (asynchronous) |
| mosi_i | input | 1 | Controller-to-peripheral data |
| miso_i | input | 1 | Peripheral-to-controller data |
| cfg_line_i | input | 2 | Line select: 0 MOSI, 1 MISO, 2/3 both |
| cfg_cs_pol_i | input | 1 | Chip-select active level |
| cfg_len_i | input | 2 | Pattern length minus one |
| cfg_mosi_val_i | input | 32 | MOSI pattern bytes, byte k at [8k+7:8k] |
| cfg_mosi_care_i | input | 4 | MOSI care flags, bit k for byte k |
| cfg_miso_val_i | input | 32 | MISO pattern bytes |
| cfg_miso_care_i | input | 4 | MISO care flags |
| trig_o | output | 1 | One-cycle match pulse |

## Verification
The bench covers the following corner cases:

- **Bit order.** It sends the bit-reversed form of a command byte. A deserialiser that took bits LSB first would trigger on this frame.
- **Offset matching.** It places the pattern at byte offset 1. A matcher that slid along the stream instead of anchoring at chip select would fire.
- **Aborted frames.** It cuts a matching frame off in the middle of a byte and then sends a clean frame. A design that kept stale bits or a stale match flag would either trigger on the aborted frame or misalign the next one.
- **Combined mode.** It drives frames where only one of the two lines matches. An OR instead of an AND would fire on these.
- **Wildcard example.** It runs the command-plus-wildcards example, with a care flag only on MOSI byte 0 and only on MISO byte 3.
- **Length and polarity.** A one-byte pattern is followed by several more bytes, which catches repeated pulses within one frame. A frame is also run with active-high chip select.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [1:0] {
    LINE_MOSI  = 2'd0,
    LINE_MISO  = 2'd1,
    LINE_BOTH  = 2'd2,
    LINE_BOTH2 = 2'd3
  } line_sel_e;
endpackage

// File: rtl/spt_sync.sv
module spt_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spt_deser.sv
module spt_deser #(
  parameter int MAX_BYTES = 4,
  localparam int IDX_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_s_i,
  input  logic             cs_act_i,
  input  logic             mosi_s_i,
  input  logic             miso_s_i,
  output logic             frame_start_o,
  output logic             byte_vld_o,
  output logic [7:0]       mosi_byte_o,
  output logic [7:0]       miso_byte_o,
  output logic [IDX_W-1:0] byte_idx_o
);
  logic             sclk_q, cs_q;
  logic [6:0]       mo_sr, mi_sr;
  logic [2:0]       bit_cnt;
  logic [IDX_W-1:0] byte_cnt;
  logic             rise;

  assign frame_start_o = cs_act_i & ~cs_q;
  assign rise          = sclk_s_i & ~sclk_q & cs_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= 1'b0;
      cs_q        <= 1'b0;
      mo_sr       <= '0;
      mi_sr       <= '0;
      bit_cnt     <= '0;
      byte_cnt    <= '0;
      byte_vld_o  <= 1'b0;
      mosi_byte_o <= '0;
      miso_byte_o <= '0;
      byte_idx_o  <= '0;
    end else begin
      sclk_q     <= sclk_s_i;
      cs_q       <= cs_act_i;
      byte_vld_o <= 1'b0;
      if (!cs_act_i || frame_start_o) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
      end else if (rise) begin
        mo_sr   <= {mo_sr[5:0], mosi_s_i};
        mi_sr   <= {mi_sr[5:0], miso_s_i};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld_o  <= 1'b1;
          mosi_byte_o <= {mo_sr, mosi_s_i};
          miso_byte_o <= {mi_sr, miso_s_i};
          byte_idx_o  <= byte_cnt;
          // saturate: positions past the table never match
          if (byte_cnt != IDX_W'(MAX_BYTES)) byte_cnt <= byte_cnt + 1'b1;
        end
      end
    end
  end

  assert_idle_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (bit_cnt == 3'd0 && byte_cnt == '0));
  assert_byte_on_edge_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(sclk_s_i) && !$past(sclk_q));
endmodule

// File: rtl/spt_match.sv
module spt_match
  import spt_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  localparam int IDX_W    = $clog2(MAX_BYTES + 1),
  localparam int LEN_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_act_i,
  input  logic                   frame_start_i,
  input  logic                   byte_vld_i,
  input  logic [7:0]             mosi_byte_i,
  input  logic [7:0]             miso_byte_i,
  input  logic [IDX_W-1:0]       byte_idx_i,
  input  line_sel_e              line_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [8*MAX_BYTES-1:0] mosi_val_i,
  input  logic [MAX_BYTES-1:0]   mosi_care_i,
  input  logic [8*MAX_BYTES-1:0] miso_val_i,
  input  logic [MAX_BYTES-1:0]   miso_care_i,
  output logic                   trig_o
);
  logic [MAX_BYTES-1:0] hit_mo, hit_mi;
  logic                 sel_mo, sel_mi, hit, in_pat, last, ok_q, fired_q;

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_cmp
    assign hit_mo[k] = !mosi_care_i[k] || (mosi_byte_i == mosi_val_i[8*k +: 8]);
    assign hit_mi[k] = !miso_care_i[k] || (miso_byte_i == miso_val_i[8*k +: 8]);
  end

  always_comb begin
    sel_mo = 1'b0;
    sel_mi = 1'b0;
    for (int k = 0; k < MAX_BYTES; k++) begin
      if (byte_idx_i == IDX_W'(k)) begin
        sel_mo = hit_mo[k];
        sel_mi = hit_mi[k];
      end
    end
    unique case (line_i)
      LINE_MOSI: hit = sel_mo;
      LINE_MISO: hit = sel_mi;
      default:   hit = sel_mo & sel_mi;
    endcase
  end

  assign in_pat = byte_idx_i <= IDX_W'(len_i);
  assign last   = byte_idx_i == IDX_W'(len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q    <= 1'b1;
      trig_o  <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      trig_o <= 1'b0;
      if (!cs_act_i || frame_start_i) begin
        ok_q    <= 1'b1;
        fired_q <= 1'b0;
      end else begin
        if (trig_o) fired_q <= 1'b1;
        if (byte_vld_i && in_pat) begin
          if (last && ok_q && hit) trig_o <= 1'b1;
          ok_q <= ok_q & hit;
        end
      end
    end
  end

  assert_trig_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  assert_one_per_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !fired_q);
  assert_trig_at_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(byte_vld_i) && ($past(byte_idx_i) == IDX_W'($past(len_i))));
endmodule

// File: rtl/spi_pattern_trigger.sv
module spi_pattern_trigger
  import spt_pkg::*;
#(
  parameter int MAX_BYTES   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(MAX_BYTES + 1),
  localparam int LEN_W      = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   cs_i,
  input  logic                   mosi_i,
  input  logic                   miso_i,
  input  logic [1:0]             cfg_line_i,
  input  logic                   cfg_cs_pol_i,
  input  logic [LEN_W-1:0]       cfg_len_i,
  input  logic [8*MAX_BYTES-1:0] cfg_mosi_val_i,
  input  logic [MAX_BYTES-1:0]   cfg_mosi_care_i,
  input  logic [8*MAX_BYTES-1:0] cfg_miso_val_i,
  input  logic [MAX_BYTES-1:0]   cfg_miso_care_i,
  output logic                   trig_o
);
  logic [3:0]       pins_s;
  logic             cs_act, frame_start, byte_vld;
  logic [7:0]       mosi_byte, miso_byte;
  logic [IDX_W-1:0] byte_idx;

  spt_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_i, mosi_i, miso_i}),
    .q_o   (pins_s)
  );

  assign cs_act = cfg_cs_pol_i ? pins_s[2] : ~pins_s[2];

  spt_deser #(.MAX_BYTES(MAX_BYTES)) u_deser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_s_i     (pins_s[3]),
    .cs_act_i     (cs_act),
    .mosi_s_i     (pins_s[1]),
    .miso_s_i     (pins_s[0]),
    .frame_start_o(frame_start),
    .byte_vld_o   (byte_vld),
    .mosi_byte_o  (mosi_byte),
    .miso_byte_o  (miso_byte),
    .byte_idx_o   (byte_idx)
  );

  spt_match #(.MAX_BYTES(MAX_BYTES)) u_match (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_act_i     (cs_act),
    .frame_start_i(frame_start),
    .byte_vld_i   (byte_vld),
    .mosi_byte_i  (mosi_byte),
    .miso_byte_i  (miso_byte),
    .byte_idx_i   (byte_idx),
    .line_i       (line_sel_e'(cfg_line_i)),
    .len_i        (cfg_len_i),
    .mosi_val_i   (cfg_mosi_val_i),
    .mosi_care_i  (cfg_mosi_care_i),
    .miso_val_i   (cfg_miso_val_i),
    .miso_care_i  (cfg_miso_care_i),
    .trig_o       (trig_o)
  );

  assert_byte_idx_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld |-> byte_idx <= IDX_W'(MAX_BYTES));
endmodule

// File: tb/spi_pattern_trigger_tb.sv
module spi_pattern_trigger_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs = 1'b1, mosi = 1'b0, miso = 1'b0;
  logic [1:0]  line = 2'd0;
  logic        pol = 1'b0;
  logic [1:0]  len = 2'd0;
  logic [31:0] mval = '0, ival = '0;
  logic [3:0]  mcare = '0, icare = '0;
  logic        trig;

  int    cyc = 0, sched = -100, checks = 0, fails = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_pattern_trigger dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_i(cs), .mosi_i(mosi), .miso_i(miso),
    .cfg_line_i(line), .cfg_cs_pol_i(pol), .cfg_len_i(len),
    .cfg_mosi_val_i(mval), .cfg_mosi_care_i(mcare),
    .cfg_miso_val_i(ival), .cfg_miso_care_i(icare), .trig_o(trig)
  );

  // per-clock comparison against the scheduled trigger cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (trig !== (cyc == sched)) begin
        fails++;
        $display("FAIL %s cyc=%0d trig actual=%b expected=%b", cur_req, cyc, trig, cyc == sched);
      end
    end
  end

  function automatic bit model_hit(input logic [63:0] mo, input logic [63:0] mi, input int nbits);
    int n = int'(len) + 1;
    bit ok = 1;
    if (nbits < 8 * n) return 0;
    for (int k = 0; k < n; k++) begin
      bit a = !mcare[k] || (mo[8*k +: 8] == mval[8*k +: 8]);
      bit b = !icare[k] || (mi[8*k +: 8] == ival[8*k +: 8]);
      if (line == 2'd0) ok &= a;
      else if (line == 2'd1) ok &= b;
      else ok &= a & b;
    end
    return ok;
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frame(input logic [63:0] mo, input logic [63:0] mi, input int nbits);
    bit exp_t = model_hit(mo, mi, nbits);
    int last  = 8 * (int'(len) + 1) - 1;
    @(negedge clk);
    cs = pol;
    wait_n(6);
    for (int b = 0; b < nbits; b++) begin
      sclk = 1'b0;
      mosi = mo[8*(b/8) + 7 - (b%8)];
      miso = mi[8*(b/8) + 7 - (b%8)];
      wait_n(4);
      sclk = 1'b1;
      if (exp_t && b == last) sched = cyc + 4;
      wait_n(4);
    end
    sclk = 1'b0;
    wait_n(4);
    cs = ~pol;
    wait_n(10);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired (%s) actual=hung expected=done", cur_req);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    checks++;
    if (trig !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset trig actual=%b expected=0", trig);
    end
    wait_n(10);

    // R2: MOSI command 03, then A5
    cur_req = "R2"; line = 2'd0; len = 2'd1;
    mval = 32'h0000_A503; mcare = 4'b0011; ival = 32'h0000_0000; icare = 4'b0011;
    frame(64'h0000_0000_0000_A503, 64'h0000_0000_0000_FFFF, 24);
    frame(64'h0000_0000_0000_A603, 64'h0, 16);

    // R3: MISO only, MOSI content irrelevant
    cur_req = "R3"; line = 2'd1; ival = 32'h0000_3C81;
    frame(64'h0000_0000_0000_1234, 64'h0000_0000_0000_3C81, 16);
    frame(64'h0000_0000_0000_A503, 64'h0000_0000_0000_3C80, 16);

    // R4: both lines must match
    cur_req = "R4"; line = 2'd2;
    frame(64'h0000_0000_0000_A503, 64'h0000_0000_0000_0000, 16);
    frame(64'h0000_0000_0000_0000, 64'h0000_0000_0000_3C81, 16);
    frame(64'h0000_0000_0000_A503, 64'h0000_0000_0000_3C81, 16);
    line = 2'd3;
    frame(64'h0000_0000_0000_A503, 64'h0000_0000_0000_3C81, 16);

    // R5: command 03, two wildcard bytes, first returned byte 00
    cur_req = "R5"; line = 2'd2; len = 2'd3;
    mval = 32'h0000_0003; mcare = 4'b0001; ival = 32'h0000_0000; icare = 4'b1000;
    frame(64'h0000_0000_7722_1103, 64'h0000_0000_00FF_EE99, 32);
    frame(64'h0000_0000_0000_8803, 64'h0000_0000_0044_5566, 32);
    frame(64'h0000_0000_0000_0003, 64'h0000_0000_0100_0000, 32);

    // R6/R10: one-byte pattern, extra bytes produce no further pulse
    cur_req = "R6"; line = 2'd0; len = 2'd0; mval = 32'h0000_005A; mcare = 4'b0001;
    frame(64'h0000_5A5A_5A5A_5A5A, 64'h0, 48);
    cur_req = "R10";
    frame(64'h0000_0000_5A5A_5A5A, 64'h0, 32);

    // R7: pattern at offset 1 must not fire
    cur_req = "R7"; len = 2'd1; mval = 32'h0000_A503; mcare = 4'b0011;
    frame(64'h0000_0000_00A5_0300, 64'h0, 24);

    // R11: bit-reversed 03 (C0) is a different byte
    cur_req = "R11"; len = 2'd0; mval = 32'h0000_0003; mcare = 4'b0001;
    frame(64'h0000_0000_0000_00C0, 64'h0, 8);
    frame(64'h0000_0000_0000_0003, 64'h0, 8);

    // R9: abort mid-byte, then a clean frame
    cur_req = "R9"; len = 2'd1; mval = 32'h0000_A503; mcare = 4'b0011;
    frame(64'h0000_0000_0000_A503, 64'h0, 12);
    frame(64'h0000_0000_0000_0003, 64'h0, 5);
    frame(64'h0000_0000_0000_A503, 64'h0, 16);

    // R8: active-high chip select
    cur_req = "R8";
    @(negedge clk); cs = 1'b0; pol = 1'b1;
    wait_n(10);
    frame(64'h0000_0000_0000_A503, 64'h0, 16);
    frame(64'h0000_0000_0000_A504, 64'h0, 16);

    wait_n(10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule